// File: doc/BRIEF.md
# Signed Multiply Unit with Held Multiplicand and Product Registers

This block multiplies two 16-bit two's-complement numbers into a full 32-bit signed result. It is built as a multiplicand register, a combinational partial-product array and a product register. A load strobe copies the data word into the multiplicand register. The value stays there until the next load, so a run of multiplies can reuse one coefficient.

A multiply strobe picks the second operand. With the immediate select low, the operand is the data word. With it high, the operand is a 13-bit signed constant, sign-extended to 16 bits. The unit multiplies that operand by the held multiplicand and stores the 32-bit result in the product register on the same clock edge. The accumulator datapath reads the registered product. Accumulation and instruction decode are handled outside this block.

Top module: `tp_multiplier`

## Requirements
- R1: With `use_imm` low, a multiply produces the exact signed 32-bit product of the held multiplicand and `data_in`, both read as two's-complement 16-bit values.
- R2: The product register captures the result on the rising clock edge at which `mul_go` is high. The new value is visible on `product` right after that edge, and the old value is shown until then.
- R3: With `use_imm` high, the second operand is `imm_in` (13 bits, bit 12 is the sign), sign-extended to 16 bits. For example, 13'h1FFF means -1 and 13'h1000 means -4096.
- R4: On any edge where `mul_go` is low, `product` keeps its value, whatever the other inputs do.
- R5: `load_mcand` high at a rising edge copies `data_in` into the multiplicand register. The value is kept across any number of multiplies until the next load.
- R6: If `load_mcand` and `mul_go` are high at the same edge, the multiply uses the multiplicand held before that edge. The newly loaded value is used from the following multiply onwards.
- R7: Synchronous active-high `rst` clears both the multiplicand and the product to zero.
- R8: -32768 × -32768 gives 32'h4000_0000, and -32768 × 32767 gives 32'hC000_8000, both exactly.
- R9: `imm_in` has no effect on a multiply while `use_imm` is low, and `data_in` has no effect on the operand while `use_imm` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_mcand | input | 1 | Load multiplicand register from `data_in` |
| mul_go | input | 1 | Multiply and capture into product register |
| use_imm | input | 1 | Select immediate operand instead of data word |
| data_in | input | 16 | Data word: multiplicand source or data operand |
| imm_in | input | 13 | Signed immediate operand |
| product | output | 32 | Registered signed product |

## Verification
On every cycle, the bound checker checks the following:
- the product and the multiplicand hold when their strobes are low;
- both registers clear after reset;
- each multiply equals the signed product of the previous multiplicand and the selected operand, for both the data source and the sign-extended immediate source.

The directed scenarios cover what those per-cycle properties cannot show on their own:
- the exact values at the extreme operand corners;
- reuse of one multiplicand over a long run;
- the ordering when a load and a multiply share an edge, seen only through later products;
- that the unselected operand input leaves the result untouched.

// File: rtl/tp_mul_pkg.sv
package tp_mul_pkg;

    localparam int WORD_W = 16;
    localparam int IMM_W  = 13;
    localparam int PROD_W = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PROD_W-1:0] prod_t;

    // Per-cycle control carried through the datapath
    typedef struct packed {
        logic load;
        logic mul;
        logic use_imm;
    } ctl_t;

    // Second-operand source
    typedef enum logic {
        SRC_DATA = 1'b0,
        SRC_IMM  = 1'b1
    } src_e;

    function automatic word_t sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/tp_hold_reg.sv
module tp_hold_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/tp_operand_sel.sv
module tp_operand_sel
    import tp_mul_pkg::*;
(
    input  src_e               src,
    input  word_t              data,
    input  logic [IMM_W-1:0]   imm,
    output word_t              operand
);
    always_comb begin
        unique case (src)
            SRC_IMM:  operand = sext_imm(imm);
            default:  operand = data;
        endcase
    end
endmodule

// File: rtl/tp_mul_array.sv
module tp_mul_array #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] rows [W];

    assign a_ext = {{W{a[W-1]}}, a};

    // Rows weighted by b[i]; the sign bit of b carries negative weight
    for (genvar i = 0; i < W; i++) begin : g_row
        if (i == W - 1) begin : g_neg
            assign rows[i] = b[i] ? (PW'(0) - (a_ext << i)) : '0;
        end else begin : g_pos
            assign rows[i] = b[i] ? (a_ext << i) : '0;
        end
    end

    always_comb begin
        p = '0;
        for (int k = 0; k < W; k++)
            p = p + rows[k];
    end
endmodule

// File: rtl/tp_multiplier.sv
module tp_multiplier
    import tp_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_mcand,
    input  logic              mul_go,
    input  logic              use_imm,
    input  logic [15:0]       data_in,
    input  logic [12:0]       imm_in,
    output logic [31:0]       product
);
    ctl_t  ctl;
    word_t mcand_q;
    word_t operand;
    prod_t prod_d;

    assign ctl = '{load: load_mcand, mul: mul_go, use_imm: use_imm};

    tp_hold_reg #(.W(WORD_W)) u_mcand (
        .clk (clk),
        .rst (rst),
        .en  (ctl.load),
        .d   (data_in),
        .q   (mcand_q)
    );

    tp_operand_sel u_sel (
        .src     (src_e'(ctl.use_imm)),
        .data    (data_in),
        .imm     (imm_in),
        .operand (operand)
    );

    tp_mul_array #(.W(WORD_W)) u_array (
        .a (mcand_q),
        .b (operand),
        .p (prod_d)
    );

    tp_hold_reg #(.W(PROD_W)) u_prod (
        .clk (clk),
        .rst (rst),
        .en  (ctl.mul),
        .d   (prod_d),
        .q   (product)
    );
endmodule

// File: rtl/tp_multiplier_chk.sv
module tp_multiplier_chk (
    input logic        clk,
    input logic        rst,
    input logic        load_mcand,
    input logic        mul_go,
    input logic        use_imm,
    input logic [15:0] data_in,
    input logic [12:0] imm_in,
    input logic [15:0] mcand_q,
    input logic [31:0] product
);
    function automatic logic [31:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
        logic signed [31:0] xs;
        logic signed [31:0] ys;
        xs = $signed(x);
        ys = $signed(y);
        return xs * ys;
    endfunction

    // R4: product holds without a multiply strobe
    p_prod_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !mul_go |=> $stable(product));

    // R5: multiplicand holds without a load strobe
    p_mcand_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load_mcand |=> $stable(mcand_q));

    // R7: reset clears both registers
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (product == 32'd0 && mcand_q == 16'd0));

    // R1 R2 R6: data-operand multiply uses the pre-edge multiplicand
    p_data_mul_r1: assert property (@(posedge clk) disable iff (rst)
        (mul_go && !use_imm) |=>
            product == ref_mul($past(mcand_q), $past(data_in)));

    // R3: immediate-operand multiply uses the sign-extended constant
    p_imm_mul_r3: assert property (@(posedge clk) disable iff (rst)
        (mul_go && use_imm) |=>
            product == ref_mul($past(mcand_q), {{3{$past(imm_in[12])}}, $past(imm_in)}));

    // R5: a load captures the data word
    p_mcand_load_r5: assert property (@(posedge clk) disable iff (rst)
        load_mcand |=> mcand_q == $past(data_in));
endmodule

bind tp_multiplier tp_multiplier_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_mcand (load_mcand),
    .mul_go     (mul_go),
    .use_imm    (use_imm),
    .data_in    (data_in),
    .imm_in     (imm_in),
    .mcand_q    (mcand_q),
    .product    (product)
);

// File: tb/tb_tp_multiplier.sv
module tb_tp_multiplier;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_mcand;
    logic        mul_go;
    logic        use_imm;
    logic [15:0] data_in;
    logic [12:0] imm_in;
    logic [31:0] product;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [15:0] model_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    tp_multiplier dut (
        .clk        (clk),
        .rst        (rst),
        .load_mcand (load_mcand),
        .mul_go     (mul_go),
        .use_imm    (use_imm),
        .data_in    (data_in),
        .imm_in     (imm_in),
        .product    (product)
    );

    function automatic logic [31:0] expect_mul(input logic [15:0] x, input logic [15:0] y);
        longint sx;
        longint sy;
        sx = $signed(x);
        sy = $signed(y);
        return 32'(sx * sy);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        load_mcand = 1'b0; mul_go = 1'b0; use_imm = 1'b0;
    endtask

    // One clock with the given controls; inputs go idle after the edge
    task automatic step(input logic ld, input logic mg, input logic ui,
                        input logic [15:0] d, input logic [12:0] im);
        load_mcand = ld; mul_go = mg; use_imm = ui; data_in = d; imm_in = im;
        @(posedge clk); #1;
        if (mg) model_m = model_m;
        if (ld) model_m = d;
        idle();
    endtask

    task automatic load(input logic [15:0] m);
        step(1'b1, 1'b0, 1'b0, m, 13'h0AAA);
    endtask

    task automatic mul_data(input string req, input logic [15:0] d);
        logic [31:0] e;
        e = expect_mul(model_m, d);
        step(1'b0, 1'b1, 1'b0, d, 13'h1555);
        check(req, product, e);
    endtask

    task automatic mul_imm(input string req, input logic [12:0] im);
        logic [31:0] e;
        e = expect_mul(model_m, {{3{im[12]}}, im});
        step(1'b0, 1'b1, 1'b1, 16'hBEEF, im);
        check(req, product, e);
    endtask

    task automatic t_reset();
        rst = 1'b1; idle(); data_in = 16'h7FFF; imm_in = '0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        model_m = 16'h0;
        check("R7 product reset", product, 32'd0);
        mul_data("R7 multiplicand cleared", 16'h1234);
    endtask

    task automatic t_basic();
        load(16'd3);
        mul_data("R1 3*7", 16'd7);
        load(-16'sd5);
        mul_data("R1 -5*100", 16'd100);
        // R2: product shows old value before the edge
        load_mcand = 1'b0; mul_go = 1'b1; use_imm = 1'b0; data_in = 16'd9;
        @(negedge clk);
        check("R2 before edge", product, expect_mul(-16'sd5, 16'd100));
        @(posedge clk); #1;
        idle();
        check("R2 after edge", product, expect_mul(-16'sd5, 16'd9));
    endtask

    task automatic t_reuse();
        load(16'd1000);
        mul_data("R5 reuse a", -16'sd3);
        mul_data("R5 reuse b", 16'd17);
        mul_data("R5 reuse c", 16'd32767);
    endtask

    task automatic t_imm();
        load(16'd7);
        mul_imm("R3 imm -1", 13'h1FFF);
        mul_imm("R3 imm 4095", 13'h0FFF);
        mul_imm("R3 imm -4096", 13'h1000);
        check("R3 value -28672", product, 32'hFFFF_9000);
    endtask

    task automatic t_ignore();
        load(16'd21);
        step(1'b0, 1'b1, 1'b0, 16'd4, 13'h0000);
        check("R9 imm ignored a", product, 32'd84);
        step(1'b0, 1'b1, 1'b0, 16'd4, 13'h1F0F);
        check("R9 imm ignored b", product, 32'd84);
        step(1'b0, 1'b1, 1'b1, 16'h0000, 13'd5);
        check("R9 data ignored a", product, 32'd105);
        step(1'b0, 1'b1, 1'b1, 16'hFFFF, 13'd5);
        check("R9 data ignored b", product, 32'd105);
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        keep = product;
        step(1'b0, 1'b0, 1'b1, 16'h8001, 13'h1234);
        step(1'b0, 1'b0, 1'b0, 16'h7777, 13'h0321);
        check("R4 product held", product, keep);
    endtask

    task automatic t_concurrent();
        load(16'd11);
        step(1'b1, 1'b1, 1'b0, 16'd22, 13'h0);
        check("R6 old multiplicand", product, 32'd242);
        mul_data("R6 new multiplicand", 16'd2);
        check("R6 value 44", product, 32'd44);
    endtask

    task automatic t_corner();
        load(16'h8000);
        mul_data("R8 min*min", 16'h8000);
        check("R8 min*min exact", product, 32'h4000_0000);
        mul_data("R8 min*max", 16'h7FFF);
        check("R8 min*max exact", product, 32'hC000_8000);
    endtask

    initial begin
        idle(); data_in = '0; imm_in = '0; rst = 1'b1; model_m = '0;
        t_reset();
        t_basic();
        t_reuse();
        t_imm();
        t_ignore();
        t_hold();
        t_concurrent();
        t_corner();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule